// File: doc/BRIEF.md
# External Data Memory Bus Controller

This block sits between a fixed-point signal processor core and a single external 16-bit data memory. The memory space is split into two banks, X and Y, chosen by a select line. The core issues one read or one write at a time over a valid/ready request port. The controller then drives the address, bank select, write data and active-low read or write strobe. It stretches a read for as long as the memory holds its wait input low. When the access ends, it returns read data together with a one-cycle completion pulse.

An external master can claim the memory bus with an active-low hold request. The controller grants the bus only between accesses, never during one. It signals the grant on an active-low acknowledge and stops driving the bus. Core requests that arrive while the bus is handed over are stalled until the hold request returns high.

High impedance is expressed as output enables that go to the pad ring. One enable covers select, address and both strobes. A second enable covers the data bus. Both enables are off whenever no access is in progress, which includes both idle cycles and hold. The address value keeps its last level between accesses and is zero from reset until the first access.

Top module: `xmem_bus_ctrl`

## Requirements
- R1: After reset: `ext_addr_o` = 0, `ext_rd_no` = `ext_wr_no` = `bus_busy_no` = `hold_ack_no` = 1, both output enables = 0, `rsp_done_o` = 0, and `req_ready_o` = 1 while `hold_req_ni` is high.
- R2: An accepted write (`req_we_i` = 1) produces exactly one cycle with all of the following: `ext_wr_no` = 0, `bus_busy_no` = 0, `ext_ctl_oe_o` = 1 and `ext_data_oe_o` = 1, with the request's address, bank and data on the bus. That cycle is the one right after the accepting edge, and `rsp_done_o` pulses in the next cycle.
- R3: An accepted read (`req_we_i` = 0) holds `ext_rd_no` = 0 for one cycle plus one cycle per cycle that `ext_wait_ni` is 0. It samples `ext_rdata_i` on the first cycle in which `ext_wait_ni` is 1. In the following cycle, `rsp_rdata_o` shows that value and `rsp_done_o` = 1.
- R4: `ext_sel_o` equals the request's bank bit during the access: 0 selects the X bank and 1 selects the Y bank.
- R5: `ext_addr_o` changes only on an accepting edge and otherwise keeps its previous value. From reset it stays 0 until the first access.
- R6: `ext_ctl_oe_o` is 1 only while a strobe is low. `ext_data_oe_o` is 1 only while `ext_wr_no` is low. Both are 0 in idle cycles and during hold.
- R7: When `hold_req_ni` is low, `hold_ack_no` goes low only after any access in progress has finished. While the request is pending or granted, `req_ready_o` = 0 and no strobe or `bus_busy_no` is asserted.
- R8: When `hold_req_ni` returns high, `hold_ack_no` returns high. A core request stalled during hold is then accepted and performed.
- R9: `rsp_done_o` is a single-cycle pulse. `req_ready_o` is 1 only when the controller is idle and no hold is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Core request valid |
| req_ready_o | output | 1 | Controller can accept a request |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_bank_i | input | 1 | 0 = X bank, 1 = Y bank |
| req_addr_i | input | 14 | Word address |
| req_wdata_i | input | 16 | Write data |
| rsp_done_o | output | 1 | One-cycle completion pulse |
| rsp_rdata_o | output | 16 | Captured read data |
| ext_sel_o | output | 1 | Bank select to memory |
| ext_addr_o | output | 14 | Address to memory |
| ext_wdata_o | output | 16 | Data bus output value |
| ext_rdata_i | input | 16 | Data bus input value |
| ext_rd_no | output | 1 | Read strobe, active low |
| ext_wr_no | output | 1 | Write strobe, active low |
| ext_wait_ni | input | 1 | 1 = ready, 0 = insert wait |
| ext_ctl_oe_o | output | 1 | Enable for select, address and strobes |
| ext_data_oe_o | output | 1 | Enable for the data bus |
| hold_req_ni | input | 1 | External master bus request, active low |
| hold_ack_no | output | 1 | Bus granted to external master, active low |
| bus_busy_no | output | 1 | Low while the controller occupies the bus |

## Verification
The hardest case to reach is a hold request that arrives in the middle of a read being stretched by wait. The grant must wait until the read finishes, and it must not cut the read short. The stimulus starts a read, holds `ext_wait_ni` low for several cycles, and lowers `hold_req_ni` partway through. It then checks that the strobe stays low and `hold_ack_no` stays high until the read completes. After that it checks that the grant follows. A second case parks a core request during hold and confirms that the request is performed only after the release.

// File: rtl/xmem_pkg.sv
package xmem_pkg;
  parameter int unsigned XM_ADDR_W = 14;
  parameter int unsigned XM_DATA_W = 16;
  parameter int unsigned XM_SYNC_STAGES = 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WR   = 2'd1,
    ST_RD   = 2'd2,
    ST_HOLD = 2'd3
  } xm_state_e;
endpackage

// File: rtl/xmem_sync.sv
module xmem_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  if (STAGES == 0) begin : g_bypass
    assign q_o = d_i;
  end else begin : g_chain
    logic [STAGES-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q <= {STAGES{RST_VAL}};
      end else begin
        q[0] <= d_i;
        for (int i = 1; i < int'(STAGES); i++) q[i] <= q[i-1];
      end
    end
    assign q_o = q[STAGES-1];
  end
endmodule

// File: rtl/xmem_seq.sv
module xmem_seq
  import xmem_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      req_valid_i,
  input  logic      req_we_i,
  input  logic      hold_free_i,
  input  logic      wait_ni,
  output xm_state_e state_o,
  output logic      accept_o,
  output logic      capture_o,
  output logic      done_o
);
  xm_state_e state_q, state_d;
  logic      done_q;

  assign accept_o  = (state_q == ST_IDLE) && hold_free_i && req_valid_i;
  assign capture_o = (state_q == ST_RD) && wait_ni;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        // hold is only taken between accesses and beats a core request
        if (!hold_free_i)     state_d = ST_HOLD;
        else if (req_valid_i) state_d = req_we_i ? ST_WR : ST_RD;
      end
      ST_WR:   state_d = ST_IDLE;
      ST_RD:   if (wait_ni) state_d = ST_IDLE;
      ST_HOLD: if (hold_free_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == ST_WR) || capture_o;
    end
  end

  assign state_o = state_q;
  assign done_o  = done_q;
endmodule

// File: rtl/xmem_latch.sv
module xmem_latch #(
  parameter int unsigned AW = 14,
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          accept_i,
  input  logic          capture_i,
  input  logic [AW-1:0] addr_i,
  input  logic          bank_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] rdata_i,
  output logic [AW-1:0] addr_o,
  output logic          bank_o,
  output logic [DW-1:0] wdata_o,
  output logic [DW-1:0] rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o  <= '0;
      bank_o  <= 1'b0;
      wdata_o <= '0;
    end else if (accept_i) begin
      addr_o  <= addr_i;
      bank_o  <= bank_i;
      wdata_o <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rdata_o <= '0;
    else if (capture_i) rdata_o <= rdata_i;
  end
endmodule

// File: rtl/xmem_bus_ctrl.sv
module xmem_bus_ctrl
  import xmem_pkg::*;
#(
  parameter int unsigned AW          = XM_ADDR_W,
  parameter int unsigned DW          = XM_DATA_W,
  parameter int unsigned SYNC_STAGES = XM_SYNC_STAGES
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_we_i,
  input  logic          req_bank_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          rsp_done_o,
  output logic [DW-1:0] rsp_rdata_o,
  output logic          ext_sel_o,
  output logic [AW-1:0] ext_addr_o,
  output logic [DW-1:0] ext_wdata_o,
  input  logic [DW-1:0] ext_rdata_i,
  output logic          ext_rd_no,
  output logic          ext_wr_no,
  input  logic          ext_wait_ni,
  output logic          ext_ctl_oe_o,
  output logic          ext_data_oe_o,
  input  logic          hold_req_ni,
  output logic          hold_ack_no,
  output logic          bus_busy_no
);
  xm_state_e state;
  logic      hold_free, accept, capture;
  logic      in_wr, in_rd;

  xmem_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_hold_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (hold_req_ni),
    .q_o   (hold_free)
  );

  xmem_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_valid_i(req_valid_i),
    .req_we_i   (req_we_i),
    .hold_free_i(hold_free),
    .wait_ni    (ext_wait_ni),
    .state_o    (state),
    .accept_o   (accept),
    .capture_o  (capture),
    .done_o     (rsp_done_o)
  );

  xmem_latch #(.AW(AW), .DW(DW)) u_latch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .capture_i(capture),
    .addr_i   (req_addr_i),
    .bank_i   (req_bank_i),
    .wdata_i  (req_wdata_i),
    .rdata_i  (ext_rdata_i),
    .addr_o   (ext_addr_o),
    .bank_o   (ext_sel_o),
    .wdata_o  (ext_wdata_o),
    .rdata_o  (rsp_rdata_o)
  );

  assign in_wr = (state == ST_WR);
  assign in_rd = (state == ST_RD);

  assign req_ready_o   = (state == ST_IDLE) && hold_free;
  assign ext_wr_no     = ~in_wr;
  assign ext_rd_no     = ~in_rd;
  assign bus_busy_no   = ~(in_wr | in_rd);
  assign ext_ctl_oe_o  = in_wr | in_rd;
  assign ext_data_oe_o = in_wr;
  assign hold_ack_no   = ~(state == ST_HOLD);
endmodule

// File: rtl/xmem_bus_ctrl_chk.sv
module xmem_bus_ctrl_chk #(
  parameter int unsigned AW = 14
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_valid_i,
  input logic          req_ready_o,
  input logic          rsp_done_o,
  input logic [AW-1:0] ext_addr_o,
  input logic          ext_rd_no,
  input logic          ext_wr_no,
  input logic          ext_wait_ni,
  input logic          ext_ctl_oe_o,
  input logic          ext_data_oe_o,
  input logic          hold_ack_no,
  input logic          bus_busy_no
);
  a_r2_wr_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_wr_no |=> ext_wr_no);
  a_r2_wr_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_wr_no |=> rsp_done_o);
  a_r3_wait_stretch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ext_rd_no && !ext_wait_ni) |=> (!ext_rd_no && !rsp_done_o));
  a_r3_rd_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ext_rd_no && ext_wait_ni) |=> (ext_rd_no && rsp_done_o));
  a_r5_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && req_ready_o) |=> $stable(ext_addr_o));
  a_r6_data_oe_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_data_oe_o |-> !ext_wr_no);
  a_r6_hold_float: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hold_ack_no |-> (!ext_ctl_oe_o && !ext_data_oe_o));
  a_r7_hold_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hold_ack_no |-> (ext_rd_no && ext_wr_no && bus_busy_no && !req_ready_o));
  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_done_o |=> !rsp_done_o);
  a_r9_ready_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (ext_rd_no && ext_wr_no && hold_ack_no));
endmodule

bind xmem_bus_ctrl xmem_bus_ctrl_chk #(.AW(AW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_ready_o  (req_ready_o),
  .rsp_done_o   (rsp_done_o),
  .ext_addr_o   (ext_addr_o),
  .ext_rd_no    (ext_rd_no),
  .ext_wr_no    (ext_wr_no),
  .ext_wait_ni  (ext_wait_ni),
  .ext_ctl_oe_o (ext_ctl_oe_o),
  .ext_data_oe_o(ext_data_oe_o),
  .hold_ack_no  (hold_ack_no),
  .bus_busy_no  (bus_busy_no)
);

// File: tb/xmem_bus_ctrl_test.sv
module xmem_bus_ctrl_test;
  localparam int AW = 14;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0, req_bank = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0, ext_rdata = '0;
  logic ext_wait_n = 1'b1, hold_req_n = 1'b1;
  logic req_ready, rsp_done, ext_sel, ext_rd_n, ext_wr_n, ext_ctl_oe, ext_data_oe;
  logic hold_ack_n, bus_busy_n;
  logic [DW-1:0] rsp_rdata, ext_wdata;
  logic [AW-1:0] ext_addr;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  xmem_bus_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_we_i(req_we),
    .req_bank_i(req_bank), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_done_o(rsp_done), .rsp_rdata_o(rsp_rdata),
    .ext_sel_o(ext_sel), .ext_addr_o(ext_addr), .ext_wdata_o(ext_wdata),
    .ext_rdata_i(ext_rdata), .ext_rd_no(ext_rd_n), .ext_wr_no(ext_wr_n),
    .ext_wait_ni(ext_wait_n), .ext_ctl_oe_o(ext_ctl_oe), .ext_data_oe_o(ext_data_oe),
    .hold_req_ni(hold_req_n), .hold_ack_no(hold_ack_n), .bus_busy_no(bus_busy_n)
  );

  typedef struct packed {
    logic          we;
    logic          bank;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    logic [3:0]    waits;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 14'h0001, 16'hA55A, 4'd0},
    '{1'b0, 1'b0, 14'h0001, 16'h1234, 4'd0},
    '{1'b1, 1'b1, 14'h3FFF, 16'hFFFF, 4'd0},
    '{1'b0, 1'b1, 14'h3FFF, 16'h8001, 4'd3},
    '{1'b0, 1'b0, 14'h2AAA, 16'h0000, 4'd1},
    '{1'b1, 1'b0, 14'h1555, 16'h0F0F, 4'd0},
    '{1'b0, 1'b1, 14'h0000, 16'hBEEF, 4'd7},
    '{1'b1, 1'b1, 14'h0100, 16'h7FFE, 4'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v);
    @(negedge clk);
    chk("R9 ready idle", req_ready, 1);
    req_valid = 1; req_we = v.we; req_bank = v.bank;
    req_addr = v.addr; req_wdata = v.data;
    ext_wait_n = (v.waits == 0);
    ext_rdata = (v.waits == 0) ? v.data : ~v.data;
    @(negedge clk);
    req_valid = 0;
    req_addr = ~v.addr;
    if (v.we) begin
      chk("R2 wr strobe", ext_wr_n, 0);
      chk("R2 rd idle", ext_rd_n, 1);
      chk("R2 busy", bus_busy_n, 0);
      chk("R2 oe", {ext_ctl_oe, ext_data_oe}, 2'b11);
      chk("R2 wdata", ext_wdata, v.data);
      chk("R2 addr", ext_addr, v.addr);
      chk("R4 sel", ext_sel, v.bank);
      @(negedge clk);
    end else begin
      for (int i = 0; i <= int'(v.waits); i++) begin
        ext_wait_n = (i == int'(v.waits));
        ext_rdata  = (i == int'(v.waits)) ? v.data : ~v.data;
        chk("R3 rd strobe", ext_rd_n, 0);
        chk("R3 no done", rsp_done, 0);
        chk("R6 data oe off in read", ext_data_oe, 0);
        chk("R4 sel", ext_sel, v.bank);
        chk("R5 addr", ext_addr, v.addr);
        @(negedge clk);
      end
      chk("R3 rdata", rsp_rdata, v.data);
    end
    ext_wait_n = 1;
    chk("R3 done", rsp_done, 1);
    chk("R6 idle oe", {ext_ctl_oe, ext_data_oe}, 2'b00);
    chk("R2 strobes off", {ext_rd_n, ext_wr_n}, 2'b11);
    @(negedge clk);
    chk("R9 done pulse", rsp_done, 0);
    chk("R5 addr held", ext_addr, v.addr);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 addr", ext_addr, 0);
    chk("R1 strobes", {ext_rd_n, ext_wr_n, bus_busy_n, hold_ack_n}, 4'hF);
    chk("R1 oe", {ext_ctl_oe, ext_data_oe, rsp_done}, 3'b000);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1 ready", req_ready, 1);
    chk("R5 addr zero before access", ext_addr, 0);

    for (int k = 0; k < NV; k++) run_vec(VECS[k]);

    // R7: hold raised during a read stretched by wait
    @(negedge clk);
    req_valid = 1; req_we = 0; req_bank = 1; req_addr = 14'h0ABC;
    ext_wait_n = 0; ext_rdata = 16'h0000;
    @(negedge clk);
    req_valid = 0;
    hold_req_n = 0;
    for (int i = 0; i < 5; i++) begin
      chk("R7 read not cut", ext_rd_n, 0);
      chk("R7 no grant mid read", hold_ack_n, 1);
      @(negedge clk);
    end
    ext_wait_n = 1; ext_rdata = 16'hC0DE;
    @(negedge clk);
    chk("R3 rdata before hold", rsp_rdata, 16'hC0DE);
    chk("R7 ready low pending", req_ready, 0);
    @(negedge clk);
    chk("R7 grant", hold_ack_n, 0);
    chk("R6 float in hold", {ext_ctl_oe, ext_data_oe}, 2'b00);

    // R8: request stalled during hold, served after release
    req_valid = 1; req_we = 1; req_bank = 0; req_addr = 14'h0123; req_wdata = 16'h5A5A;
    repeat (3) @(negedge clk);
    chk("R7 stalled", {ext_wr_n, bus_busy_n, req_ready}, 3'b110);
    chk("R5 addr held in hold", ext_addr, 14'h0ABC);
    hold_req_n = 1;
    begin
      bit seen = 0;
      for (int i = 0; i < 10 && !seen; i++) begin
        @(negedge clk);
        if (!ext_wr_n) begin
          seen = 1;
          req_valid = 0;
          chk("R8 ack released", hold_ack_n, 1);
          chk("R8 stalled write addr", ext_addr, 14'h0123);
          chk("R8 stalled write data", ext_wdata, 16'h5A5A);
        end
      end
      chk("R8 write performed", seen, 1);
    end
    @(negedge clk);
    chk("R8 done", rsp_done, 1);
    repeat (2) @(negedge clk);
    chk("R9 ready after", req_ready, 1);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule